// File: doc/BRIEF.md
# SMBus PEC Transfer Engine

This block sequences one SMBus master transfer at bit granularity and handles the Packet Error Code without help from the host. A command carries a 7-bit target address, a direction, a byte count and a PEC enable. The engine first sends the address byte. It then moves the counted bytes, one bit per `bit_tick` slot, with an acknowledge slot after every byte. Each address, data and PEC bit also passes through a bit-serial CRC-8 register.

When PEC is enabled, the byte count includes the PEC byte. On a write, the engine replaces the last counted byte with the CRC it has accumulated. On a read, it compares the last received byte with the CRC it has computed. The CRC register is kept across a repeated start, so the PEC of a combined write-then-read covers both halves. Two sticky flags report a not-acknowledged byte and a PEC mismatch until the host clears them.

The physical bus timing (start/stop generation, clock stretching) lives outside. It presents one pulse on `bit_tick` per bit slot, reads `sda_out` while the pulse is high, and returns the sampled line level on `sda_in`.

Top module: `smbpec_engine`

## Requirements
- R1: After reset the engine is idle (`busy` low), `sda_out` is 1 (released), and `nack_flag` and `pec_err` are 0. While idle, `sda_out` stays 1.
- R2: A transfer starts with an address byte: the 7-bit address MSB first, then the direction bit (1 = read). Exactly `cmd_nbytes` further bytes follow, MSB first. Every byte is followed by one acknowledge slot, and 0 on the line means ACK.
- R3: The PEC is CRC-8 with polynomial x^8+x^2+x+1 (0x07), initial value 0x00, processed MSB first. It is updated on every address, data and PEC bit, but not on acknowledge bits. It is zeroed when a command with `cmd_restart`=0 starts, and kept when a command with `cmd_restart`=1 starts.
- R4: On a write with `cmd_pec_en`=1, the last of the `cmd_nbytes` bytes is the CRC value reached at the end of the preceding byte.
- R5: On a write, each byte taken from `tx_data` is marked by one `tx_req` pulse. A write without PEC sends all `cmd_nbytes` bytes from `tx_data` in order.
- R6: During the acknowledge slot of a byte the master sends, `sda_out` is 1. A 1 sampled there sets `nack_flag` and ends the transfer after that slot.
- R7: On a read, the master drives ACK (0) after every data byte except the last counted byte, which it answers with NACK (1). Each received byte appears on `rx_byte` with a one-cycle `rx_valid` pulse.
- R8: On a read with `cmd_pec_en`=1, a last byte that differs from the computed CRC sets `pec_err`. The flag stays set through later transfers.
- R9: On a read with `cmd_pec_en`=0, the last byte is not checked and leaves `pec_err` unchanged.
- R10: `flag_clr` clears both sticky flags. A `cmd_valid` pulse while `busy` is high is ignored.
- R11: `done` pulses for one cycle when a transfer ends, and `busy` is low from then on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | Start a command (taken only while idle) |
| cmd_restart | input | 1 | 1: repeated start, CRC kept; 0: new message, CRC zeroed |
| cmd_read | input | 1 | Direction, 1 = read |
| cmd_pec_en | input | 1 | Automatic PEC for this command |
| cmd_addr | input | 7 | Target address |
| cmd_nbytes | input | CNT_W | Bytes after the address, PEC byte included |
| tx_data | input | 8 | Next byte to send |
| tx_req | output | 1 | `tx_data` consumed this cycle |
| bit_tick | input | 1 | One pulse per bit slot |
| sda_in | input | 1 | Sampled line level for the slot |
| sda_out | output | 1 | Level to drive in the slot (1 = released) |
| rx_valid | output | 1 | Received byte valid |
| rx_byte | output | 8 | Received byte |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | Transfer finished |
| flag_clr | input | 1 | Clear sticky flags |
| nack_flag | output | 1 | Sticky: a sent byte was not acknowledged |
| pec_err | output | 1 | Sticky: received PEC mismatched |

## Verification
The hardest case to reach is a combined transfer: a write without PEC followed by a repeated-start read with PEC. The check byte then has to cover the bits of both commands, including the second address byte. The bench acts as the target. It computes the PEC over the write address, the written data, the read address and the returned data with its own CRC function, and supplies that byte. `pec_err` must stay clear. Another write that starts a new message must then produce a PEC computed from zero. A NACK on a middle data byte checks that the transfer stops early and that no further `tx_req` is raised.

// File: rtl/smbpec_pkg.sv
// Shared types and constants for the SMBus PEC transfer engine.
package smbpec_pkg;
    localparam int BYTE_W   = 8;
    localparam int ACK_SLOT = 8;                      // bit index of the acknowledge slot
    localparam logic [BYTE_W-1:0] PEC_POLY = 8'h07;   // x^8+x^2+x+1

    typedef enum logic [1:0] {
        K_ADDR = 2'd0,
        K_DATA = 2'd1,
        K_PEC  = 2'd2
    } byte_kind_t;
endpackage

// File: rtl/smbpec_crc8.sv
// Bit-serial CRC-8 register, MSB first.
// Assumes: clr and shift are never needed in the same cycle; clr has priority.
module smbpec_crc8
    import smbpec_pkg::*;
#(
    parameter logic [BYTE_W-1:0] POLY = PEC_POLY
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              shift,
    input  logic              bit_in,
    output logic [BYTE_W-1:0] crc
);
    logic              fb;
    logic [BYTE_W-1:0] crc_q;

    assign fb  = crc_q[BYTE_W-1] ^ bit_in;
    assign crc = crc_q;

    // Clear at message start, otherwise fold in one bit per shift.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            crc_q <= '0;
        end else if (shift) begin
            crc_q <= {crc_q[BYTE_W-2:0], 1'b0} ^ (fb ? POLY : '0);
        end
    end

    AST_CRC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!shift && !clr) |=> $stable(crc_q)); // R3
    AST_CRC_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (crc_q == '0)); // R3
endmodule

// File: rtl/smbpec_flags.sv
// Sticky status flags: not-acknowledged and PEC mismatch.
// Assumes: clear takes priority over a set in the same cycle.
module smbpec_flags (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic nack_set,
    input  logic pec_set,
    output logic nack_flag,
    output logic pec_err
);
    // Hold each flag until the host clears it.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            nack_flag <= 1'b0;
            pec_err   <= 1'b0;
        end else begin
            if (nack_set) nack_flag <= 1'b1;
            if (pec_set)  pec_err   <= 1'b1;
        end
    end

    AST_PEC_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (pec_err && !clr) |=> pec_err); // R8
    AST_NACK_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (nack_flag && !clr) |=> nack_flag); // R6
    AST_CLR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (!nack_flag && !pec_err)); // R10
endmodule

// File: rtl/smbpec_seq.sv
// Byte sequencer: address byte, counted data bytes, acknowledge slots,
// PEC insertion on writes and PEC comparison on reads.
// Assumes: bit_tick is a single-cycle pulse; a PEC byte is the last counted byte.
module smbpec_seq
    import smbpec_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic              cmd_restart,
    input  logic              cmd_read,
    input  logic              cmd_pec_en,
    input  logic [6:0]        cmd_addr,
    input  logic [CNT_W-1:0]  cmd_nbytes,
    input  logic [BYTE_W-1:0] tx_data,
    output logic              tx_req,
    input  logic              bit_tick,
    input  logic              sda_in,
    output logic              sda_out,
    input  logic [BYTE_W-1:0] crc_val,
    output logic              crc_clr,
    output logic              crc_shift,
    output logic              crc_bit,
    output logic              rx_valid,
    output logic [BYTE_W-1:0] rx_byte,
    output logic              nack_set,
    output logic              pec_set,
    output logic              busy,
    output logic              done
);
    localparam int IDX_W = $clog2(ACK_SLOT + 1);

    logic              busy_q, read_q, pec_q, last_q;
    byte_kind_t        kind_q;
    logic [BYTE_W-1:0] shreg_q, expect_q;
    logic [IDX_W-1:0]  idx_q;
    logic [CNT_W-1:0]  remain_q;
    logic              rx_valid_q, done_q;
    logic [BYTE_W-1:0] rx_byte_q;

    logic tx_dir, in_ack, data_tick, ack_tick, start;
    logic nack_seen, finish, advance, next_pec;

    // Slot and decision decode.
    always_comb begin
        tx_dir    = (kind_q == K_ADDR) || !read_q;
        in_ack    = (idx_q == IDX_W'(ACK_SLOT));
        data_tick = busy_q && bit_tick && !in_ack;
        ack_tick  = busy_q && bit_tick && in_ack;
        start     = cmd_valid && !busy_q;
        nack_seen = ack_tick && tx_dir && sda_in;
        finish    = ack_tick && (nack_seen || (remain_q == '0));
        advance   = ack_tick && !finish;
        next_pec  = pec_q && (remain_q == CNT_W'(1));
    end

    assign crc_clr   = start && !cmd_restart;
    assign crc_shift = data_tick;
    assign crc_bit   = tx_dir ? shreg_q[BYTE_W-1] : sda_in;
    assign nack_set  = nack_seen;
    assign tx_req    = advance && !read_q && !next_pec;
    assign pec_set   = ack_tick && !tx_dir && (kind_q == K_PEC) && (shreg_q != expect_q);

    // Line level for the current slot: data bit, release, or master acknowledge.
    always_comb begin
        if (!busy_q)     sda_out = 1'b1;
        else if (!in_ack) sda_out = tx_dir ? shreg_q[BYTE_W-1] : 1'b1;
        else             sda_out = tx_dir ? 1'b1 : last_q;
    end

    // Transfer state: load on command, shift on data slots, reload or finish on ack slots.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q     <= 1'b0;
            read_q     <= 1'b0;
            pec_q      <= 1'b0;
            last_q     <= 1'b0;
            kind_q     <= K_ADDR;
            shreg_q    <= '1;
            expect_q   <= '0;
            idx_q      <= '0;
            remain_q   <= '0;
            rx_valid_q <= 1'b0;
            rx_byte_q  <= '0;
            done_q     <= 1'b0;
        end else begin
            rx_valid_q <= 1'b0;
            done_q     <= 1'b0;
            if (start) begin
                busy_q   <= 1'b1;
                kind_q   <= K_ADDR;
                shreg_q  <= {cmd_addr, cmd_read};
                idx_q    <= '0;
                remain_q <= cmd_nbytes;
                read_q   <= cmd_read;
                pec_q    <= cmd_pec_en;
                last_q   <= 1'b0;
            end else if (data_tick) begin
                shreg_q <= {shreg_q[BYTE_W-2:0], sda_in};
                idx_q   <= idx_q + IDX_W'(1);
            end else if (ack_tick) begin
                idx_q <= '0;
                if (!tx_dir) begin
                    rx_valid_q <= 1'b1;
                    rx_byte_q  <= shreg_q;
                end
                if (finish) begin
                    busy_q <= 1'b0;
                    done_q <= 1'b1;
                end else begin
                    remain_q <= remain_q - CNT_W'(1);
                    last_q   <= (remain_q == CNT_W'(1));
                    kind_q   <= next_pec ? K_PEC : K_DATA;
                    expect_q <= crc_val;
                    if (read_q)        shreg_q <= '1;
                    else if (next_pec) shreg_q <= crc_val;
                    else               shreg_q <= tx_data;
                end
            end
        end
    end

    assign busy     = busy_q;
    assign done     = done_q;
    assign rx_valid = rx_valid_q;
    assign rx_byte  = rx_byte_q;

    AST_SLOT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        idx_q <= IDX_W'(ACK_SLOT)); // R2
    AST_PEC_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_q && kind_q == K_PEC) |-> pec_q); // R4
    AST_NACK_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
        nack_seen |=> !busy_q); // R6
    AST_RX_LAST_NACK: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_q && in_ack && !tx_dir && remain_q == '0) |-> sda_out); // R7
    AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |-> !busy_q); // R11
endmodule

// File: rtl/smbpec_engine.sv
// Top of the SMBus PEC transfer engine: sequencer, CRC-8 register and sticky flags.
// Assumes: an external bus-timing layer issues one bit_tick per bit slot.
module smbpec_engine
    import smbpec_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_valid,
    input  logic             cmd_restart,
    input  logic             cmd_read,
    input  logic             cmd_pec_en,
    input  logic [6:0]       cmd_addr,
    input  logic [CNT_W-1:0] cmd_nbytes,
    input  logic [7:0]       tx_data,
    output logic             tx_req,
    input  logic             bit_tick,
    input  logic             sda_in,
    output logic             sda_out,
    output logic             rx_valid,
    output logic [7:0]       rx_byte,
    output logic             busy,
    output logic             done,
    input  logic             flag_clr,
    output logic             nack_flag,
    output logic             pec_err
);
    logic [BYTE_W-1:0] crc_val;
    logic              crc_clr, crc_shift, crc_bit, nack_set, pec_set;

    smbpec_seq #(.CNT_W(CNT_W)) u_seq (
        .clk(clk), .rst_n(rst_n),
        .cmd_valid(cmd_valid), .cmd_restart(cmd_restart), .cmd_read(cmd_read),
        .cmd_pec_en(cmd_pec_en), .cmd_addr(cmd_addr), .cmd_nbytes(cmd_nbytes),
        .tx_data(tx_data), .tx_req(tx_req),
        .bit_tick(bit_tick), .sda_in(sda_in), .sda_out(sda_out),
        .crc_val(crc_val), .crc_clr(crc_clr), .crc_shift(crc_shift), .crc_bit(crc_bit),
        .rx_valid(rx_valid), .rx_byte(rx_byte),
        .nack_set(nack_set), .pec_set(pec_set),
        .busy(busy), .done(done)
    );

    smbpec_crc8 #(.POLY(PEC_POLY)) u_crc (
        .clk(clk), .rst_n(rst_n), .clr(crc_clr), .shift(crc_shift),
        .bit_in(crc_bit), .crc(crc_val)
    );

    smbpec_flags u_flags (
        .clk(clk), .rst_n(rst_n), .clr(flag_clr),
        .nack_set(nack_set), .pec_set(pec_set),
        .nack_flag(nack_flag), .pec_err(pec_err)
    );

    AST_IDLE_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> sda_out); // R1
endmodule

// File: tb/sim_smbpec_engine.sv
// Directed bench: the bench plays the SMBus target and checks every byte and flag.
module sim_smbpec_engine;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cmd_valid = 1'b0, cmd_restart = 1'b0, cmd_read = 1'b0, cmd_pec_en = 1'b0;
    logic [6:0] cmd_addr = '0;
    logic [7:0] cmd_nbytes = '0;
    logic [7:0] tx_data;
    logic       tx_req, bit_tick = 1'b0, sda_in = 1'b1, sda_out;
    logic       rx_valid, busy, done, flag_clr = 1'b0, nack_flag, pec_err;
    logic [7:0] rx_byte;

    int checks = 0;
    int fails  = 0;

    logic [7:0] txq [0:7];
    int tx_cnt = 0, tx_base = 0, done_cnt = 0, rx_cnt = 0;
    logic [7:0] rxlog [0:15];

    always #10 clk = ~clk;

    smbpec_engine u0 (
        .clk(clk), .rst_n(rst_n),
        .cmd_valid(cmd_valid), .cmd_restart(cmd_restart), .cmd_read(cmd_read),
        .cmd_pec_en(cmd_pec_en), .cmd_addr(cmd_addr), .cmd_nbytes(cmd_nbytes),
        .tx_data(tx_data), .tx_req(tx_req), .bit_tick(bit_tick), .sda_in(sda_in),
        .sda_out(sda_out), .rx_valid(rx_valid), .rx_byte(rx_byte), .busy(busy),
        .done(done), .flag_clr(flag_clr), .nack_flag(nack_flag), .pec_err(pec_err)
    );

    assign tx_data = txq[3'(tx_cnt - tx_base)];

    always @(posedge clk) begin
        if (tx_req) tx_cnt <= tx_cnt + 1;
        if (done) done_cnt <= done_cnt + 1;
        if (rx_valid) begin
            rxlog[rx_cnt[3:0]] <= rx_byte;
            rx_cnt <= rx_cnt + 1;
        end
    end

    function automatic logic [7:0] crc_upd(input logic [7:0] c, input logic [7:0] b);
        logic fb;
        for (int i = 7; i >= 0; i--) begin
            fb = c[7] ^ b[i];
            c  = {c[6:0], 1'b0} ^ (fb ? 8'h07 : 8'h00);
        end
        return c;
    endfunction

    task automatic chk(input logic ok, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", what, act, exp);
        end
    endtask

    task automatic bit_slot(input logic drv, output logic seen);
        @(negedge clk);
        sda_in   = drv;
        bit_tick = 1'b1;
        #1 seen  = sda_out;
        @(negedge clk);
        bit_tick = 1'b0;
        sda_in   = 1'b1;
    endtask

    task automatic slave_byte(input logic [7:0] send, input logic ack,
                              output logic [7:0] got, output logic mack);
        logic s;
        for (int i = 7; i >= 0; i--) begin
            bit_slot(send[i], s);
            got[i] = s;
        end
        bit_slot(ack, mack);
    endtask

    task automatic issue(input logic rs, input logic rd, input logic pe,
                         input logic [6:0] a, input logic [7:0] n);
        @(negedge clk);
        cmd_restart = rs; cmd_read = rd; cmd_pec_en = pe; cmd_addr = a; cmd_nbytes = n;
        cmd_valid = 1'b1;
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    task automatic pulse_clr();
        @(negedge clk); flag_clr = 1'b1;
        @(negedge clk); flag_clr = 1'b0;
    endtask

    task automatic t_reset();
        chk(!busy, "R1 busy after reset", busy, 0);
        chk(sda_out, "R1 sda released", sda_out, 1);
        chk(!nack_flag && !pec_err, "R1 flags clear", {nack_flag, pec_err}, 0);
    endtask

    task automatic t_write_pec(input logic [6:0] a, input logic [7:0] d0, input logic [7:0] d1);
        logic [7:0] got, crc; logic m; int d0c, tb0;
        txq[0] = d0; txq[1] = d1; tx_base = tx_cnt; tb0 = tx_cnt; d0c = done_cnt;
        issue(1'b0, 1'b0, 1'b1, a, 8'd3);
        slave_byte(8'hFF, 1'b0, got, m);
        chk(got == {a, 1'b0}, "R2 address byte", got, {a, 1'b0});
        chk(m == 1'b1, "R6 released in ack slot", m, 1);
        crc = crc_upd(8'h00, {a, 1'b0});
        slave_byte(8'hFF, 1'b0, got, m);
        chk(got == d0, "R2 data byte 0", got, d0);
        crc = crc_upd(crc, d0);
        slave_byte(8'hFF, 1'b0, got, m);
        chk(got == d1, "R2 data byte 1", got, d1);
        crc = crc_upd(crc, d1);
        slave_byte(8'hFF, 1'b0, got, m);
        chk(got == crc, "R4 R3 appended PEC", got, crc);
        @(negedge clk);
        chk(tx_cnt - tb0 == 2, "R5 tx_req count", tx_cnt - tb0, 2);
        chk(!busy && done_cnt == d0c + 1, "R11 done once and idle", done_cnt - d0c, 1);
        chk(!nack_flag, "R6 no nack", nack_flag, 0);
    endtask

    task automatic t_write_nopec_busy_cmd();
        logic [7:0] got; logic m; int tb0;
        txq[0] = 8'h11; txq[1] = 8'h22; tx_base = tx_cnt; tb0 = tx_cnt;
        issue(1'b0, 1'b0, 1'b0, 7'h10, 8'd2);
        slave_byte(8'hFF, 1'b0, got, m);
        issue(1'b0, 1'b1, 1'b1, 7'h7F, 8'd5);   // must be ignored while busy
        slave_byte(8'hFF, 1'b0, got, m);
        chk(got == 8'h11, "R10 R5 byte 0 after ignored cmd", got, 8'h11);
        slave_byte(8'hFF, 1'b0, got, m);
        chk(got == 8'h22, "R5 byte 1 no PEC", got, 8'h22);
        @(negedge clk);
        chk(!busy, "R10 ended at original count", busy, 0);
        chk(tx_cnt - tb0 == 2, "R5 two requests", tx_cnt - tb0, 2);
    endtask

    task automatic t_read(input logic pe, input logic corrupt, input logic [6:0] a);
        logic [7:0] got, crc, last; logic m; int r0;
        r0 = rx_cnt;
        issue(1'b0, 1'b1, pe, a, 8'd3);
        slave_byte(8'hFF, 1'b0, got, m);
        chk(got == {a, 1'b1}, "R2 read address", got, {a, 1'b1});
        crc = crc_upd(8'h00, {a, 1'b1});
        slave_byte(8'h5E, 1'b1, got, m);
        chk(m == 1'b0, "R7 ACK byte 0", m, 0);
        crc = crc_upd(crc, 8'h5E);
        slave_byte(8'h9D, 1'b1, got, m);
        chk(m == 1'b0, "R7 ACK byte 1", m, 0);
        crc = crc_upd(crc, 8'h9D);
        last = corrupt ? (crc ^ 8'h01) : crc;
        slave_byte(last, 1'b1, got, m);
        chk(m == 1'b1, "R7 NACK last byte", m, 1);
        @(negedge clk);
        chk(rx_cnt - r0 == 3 && rxlog[4'(r0 + 1)] == 8'h9D, "R7 received bytes",
            rxlog[4'(r0 + 1)], 8'h9D);
        if (!pe)
            chk(!pec_err, "R9 last byte unchecked", pec_err, 0);
        else
            chk(pec_err == corrupt, "R8 PEC compare", pec_err, corrupt);
    endtask

    task automatic t_combined();
        logic [7:0] got, crc; logic m;
        txq[0] = 8'h7E; tx_base = tx_cnt;
        issue(1'b0, 1'b0, 1'b0, 7'h2A, 8'd1);
        slave_byte(8'hFF, 1'b0, got, m);
        slave_byte(8'hFF, 1'b0, got, m);
        crc = crc_upd(crc_upd(8'h00, 8'h54), 8'h7E);
        issue(1'b1, 1'b1, 1'b1, 7'h2A, 8'd2);
        slave_byte(8'hFF, 1'b0, got, m);
        crc = crc_upd(crc_upd(crc, 8'h55), 8'hC4);
        slave_byte(8'hC4, 1'b1, got, m);
        slave_byte(crc, 1'b1, got, m);
        @(negedge clk);
        chk(!pec_err, "R3 PEC spans repeated start", pec_err, 0);
    endtask

    task automatic t_nack_mid();
        logic [7:0] got; logic m; int tb0;
        txq[0] = 8'h01; txq[1] = 8'h02; tx_base = tx_cnt; tb0 = tx_cnt;
        issue(1'b0, 1'b0, 1'b1, 7'h31, 8'd3);
        slave_byte(8'hFF, 1'b0, got, m);
        slave_byte(8'hFF, 1'b1, got, m);
        @(negedge clk);
        chk(nack_flag, "R6 nack sets flag", nack_flag, 1);
        chk(!busy, "R6 transfer ends on nack", busy, 0);
        chk(tx_cnt - tb0 == 1, "R6 no more requests", tx_cnt - tb0, 1);
        pulse_clr();
        chk(!nack_flag, "R10 clear nack", nack_flag, 0);
    endtask

    task automatic t_nack_pec();
        logic [7:0] got, crc; logic m;
        txq[0] = 8'h40; tx_base = tx_cnt;
        issue(1'b0, 1'b0, 1'b1, 7'h0C, 8'd2);
        slave_byte(8'hFF, 1'b0, got, m);
        slave_byte(8'hFF, 1'b0, got, m);
        crc = crc_upd(crc_upd(8'h00, 8'h18), 8'h40);
        slave_byte(8'hFF, 1'b1, got, m);
        chk(got == crc, "R4 PEC before nack", got, crc);
        @(negedge clk);
        chk(nack_flag && !busy, "R6 nack on PEC byte", nack_flag, 1);
        pulse_clr();
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        for (int i = 0; i < 8; i++) txq[i] = 8'h00;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_write_pec(7'h2B, 8'hA1, 8'h3C);
        t_write_nopec_busy_cmd();
        t_read(1'b1, 1'b0, 7'h33);
        t_read(1'b0, 1'b1, 7'h21);
        t_combined();
        t_write_pec(7'h55, 8'h00, 8'hFF);   // new message: CRC restarts from zero (R3)
        t_read(1'b1, 1'b1, 7'h33);
        t_write_nopec_busy_cmd();
        chk(pec_err, "R8 pec_err sticky", pec_err, 1);
        pulse_clr();
        chk(!pec_err, "R10 clear pec_err", pec_err, 0);
        t_nack_mid();
        t_nack_pec();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule